// File: doc/BRIEF.md
# USB 1.1 Host Controller Register Block

This block is the software-visible register file of a legacy full/low-speed USB host controller with two root-hub ports. It occupies a 32-byte I/O window and holds the command word, the status word, the interrupt enables, the 11-bit frame number, the frame-list base pointer, the start-of-frame timing byte and one control/status word per root port. A simple synchronous request port carries accesses. Each request has an address, a write flag, a size code and write data. Read data comes back one cycle later.

The schedule engine receives a run indication and single-cycle reset pulses from the block. The transfer logic feeds status-set strobes back into it. A hidden two-bit cause register keeps completion interrupts apart from short-packet interrupts, so that each can be enabled separately even though both raise the same status bit. The port logic tracks attach and detach events and device speed. It also emits a device reset pulse when software raises a port's reset bit. A single level interrupt output combines the enabled causes.

Top module: `usbh_regblk`

## Requirements
- R1: After `rst`, reads return the following. Command is 0, status is 0, interrupt enable is 0, frame number is 0, frame-list base is 0, the timing byte is 64 (0x40) and every port word is 0x0080. `irq` and `run` are low.
- R2: The size code is 0 for byte, 1 for word and 2 for dword; code 3 is never mapped. `rsp_valid` is high in the cycle after a read request, and `rsp_rdata` then holds the register value seen at the request.
- R3: A word write to offset 0x00 stores bits 15:0. Bit 0 is run/stop and drives `run`.
- R4: A command write that sets bit 1 or bit 2 does not store the written value. Instead it returns every register, ports included, to its R1 value. Bit 2 gives a one-cycle `bus_reset_pulse`. Bit 1 alone gives a one-cycle `hc_reset_pulse`.
- R5: The word at offset 0x02 is the status word, with these bits: 0 transfer interrupt, 1 error, 2 resume, 3 host system error, 4 process error, 5 halted. The matching `evt_*` strobes set these bits. Writing 1 to a bit clears it, and a strobe in the same cycle as a clearing write wins.
- R6: `evt_ioc` sets hidden cause bit 0, and `evt_spd` sets hidden cause bit 1. Either strobe also sets status bit 0. Writing 1 to status bit 0 clears both cause bits.
- R7: The interrupt enable is the word at 0x04, bits 3:0. `irq` is high when any of these holds: status error with enable bit 0, status resume with enable bit 1, cause bit 0 with enable bit 2, cause bit 1 with enable bit 3. `irq` is also high whenever status host-system-error or process-error is set.
- R8: The frame number is the word at 0x06 and is 11 bits wide. A write takes effect only while status bit 5 (halted) is set.
- R9: The frame-list base is the dword at 0x08, and its bits 11:0 always read as zero. The timing byte is the byte at 0x0C.
- R10: Port n has its word at 0x10+2n, with these bits: 0 connected, 1 connect change, 2 enabled, 3 enable change, 8 low speed, 9 port reset. A write keeps the old value of the bits in mask 0x01FB and takes every other bit from the data. A 1 written to bit 1 or bit 3 then clears that bit.
- R11: A write that moves port bit 9 from 0 to 1 gives a one-cycle pulse on that port's `port_reset_pulse` bit.
- R12: An attach on a port that is not connected sets bits 0 and 1. Any attach copies the speed input into bit 8. A detach on an enabled port clears bit 2 and sets bit 3.
- R13: Some reads fall outside the map. A word read of a missing port returns 0xFF7F. Other word reads return 0xFFFF, other byte reads return 0xFF, and other dword or size-3 reads return 0xFFFFFFFF. Writes outside the map change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 5 | Byte offset in the 32-byte window |
| req_size | input | 2 | 0 byte, 1 word, 2 dword |
| req_wdata | input | 32 | Write data, right aligned |
| rsp_valid | output | 1 | Read data valid (one cycle after request) |
| rsp_rdata | output | 32 | Read data |
| evt_ioc | input | 1 | Completion interrupt strobe |
| evt_spd | input | 1 | Short-packet interrupt strobe |
| evt_err | input | 1 | Transfer error strobe |
| evt_resume | input | 1 | Resume detected strobe |
| evt_hse | input | 1 | Host system error strobe |
| evt_perr | input | 1 | Process error strobe |
| evt_halt | input | 1 | Controller halted strobe |
| port_attach | input | NPORTS | Device attach strobe per port |
| port_detach | input | NPORTS | Device detach strobe per port |
| port_low_speed | input | NPORTS | Speed of attaching device (1 = low) |
| irq | output | 1 | Level interrupt |
| run | output | 1 | Run/stop bit to the schedule engine |
| hc_reset_pulse | output | 1 | Controller reset pulse |
| bus_reset_pulse | output | 1 | Global bus reset pulse |
| port_reset_pulse | output | NPORTS | Device reset pulse per port |

## Verification
The bench goes after the write-1-to-clear rules and the write-merge mask of the port words. It writes an enable without the matching change bit, and a change bit alone. A design that masked or cleared the wrong bits would drop the enable or keep a stale change flag. It drives a status strobe in the same cycle as a clearing write, and it checks that a completion cause does not fire a short-packet enable. A shared cause bit, or a clear that won over a set, would show up at `irq`. It also writes the frame number while the controller is running. It writes port reset twice, and it issues command writes whose reset bits must not be stored. A frame number that changes, a repeated reset pulse or a stored reset bit would each appear in the read-back values or on the pulse outputs.

// File: rtl/usbh_pkg.sv
package usbh_pkg;

    // access size codes carried on req_size
    typedef enum logic [1:0] {
        ACC_BYTE  = 2'd0,
        ACC_WORD  = 2'd1,
        ACC_DWORD = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    // register offsets within the 32-byte window
    localparam logic [4:0] OFS_CMD = 5'h00;
    localparam logic [4:0] OFS_STS = 5'h02;
    localparam logic [4:0] OFS_IEN = 5'h04;
    localparam logic [4:0] OFS_FRN = 5'h06;
    localparam logic [4:0] OFS_FLB = 5'h08;
    localparam logic [4:0] OFS_SOF = 5'h0C;

    // port word layout
    localparam int PB_CONN = 0;
    localparam int PB_CCHG = 1;
    localparam int PB_EN   = 2;
    localparam int PB_ECHG = 3;
    localparam int PB_LS   = 8;
    localparam int PB_RST  = 9;

    localparam logic [15:0] PORT_HOLD_MASK = 16'h01FB;
    localparam logic [15:0] PORT_W1C_MASK  = 16'h000A;
    localparam logic [15:0] PORT_INIT      = 16'h0080;
    localparam logic [15:0] PORT_ABSENT    = 16'hFF7F;
    localparam logic [7:0]  SOF_INIT       = 8'd64;

    // status word, bit 5 down to bit 0
    typedef struct packed {
        logic halted;
        logic perr;
        logic hse;
        logic resume;
        logic err;
        logic xfer;
    } sts_t;

    // hidden interrupt cause
    typedef struct packed {
        logic shortpkt;
        logic done;
    } cause_t;

    // interrupt enable, bit 3 down to bit 0
    typedef struct packed {
        logic en_short;
        logic en_done;
        logic en_resume;
        logic en_err;
    } ien_t;

    function automatic logic [15:0] port_merge(input logic [15:0] cur,
                                               input logic [15:0] wd);
        logic [15:0] v;
        v = (cur & PORT_HOLD_MASK) | (wd & ~PORT_HOLD_MASK);
        return v & ~(wd & PORT_W1C_MASK);
    endfunction

endpackage

// File: rtl/usbh_irq_gen.sv
module usbh_irq_gen
    import usbh_pkg::*;
(
    input  logic   st_err,
    input  logic   st_resume,
    input  logic   st_hse,
    input  logic   st_perr,
    input  cause_t cause,
    input  ien_t   ien,
    output logic   irq
);
    always_comb begin
        irq = (st_err    && ien.en_err)    ||
              (st_resume && ien.en_resume) ||
              (cause.done     && ien.en_done)  ||
              (cause.shortpkt && ien.en_short) ||
              st_hse || st_perr;
    end
endmodule

// File: rtl/usbh_port_csr.sv
module usbh_port_csr
    import usbh_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        soft_rst,
    input  logic        wr_en,
    input  logic [15:0] wdata,
    input  logic        attach,
    input  logic        detach,
    input  logic        low_speed,
    output logic [15:0] ctrl,
    output logic        rst_pulse
);
    logic [15:0] nxt;

    always_comb begin
        nxt = ctrl;
        if (wr_en) nxt = port_merge(ctrl, wdata);
        if (attach) begin
            if (!nxt[PB_CONN]) begin
                nxt[PB_CONN] = 1'b1;
                nxt[PB_CCHG] = 1'b1;
            end
            nxt[PB_LS] = low_speed;
        end
        if (detach && nxt[PB_EN]) begin
            nxt[PB_EN]   = 1'b0;
            nxt[PB_ECHG] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            ctrl      <= PORT_INIT;
            rst_pulse <= 1'b0;
        end else begin
            ctrl      <= nxt;
            rst_pulse <= wr_en && wdata[PB_RST] && !ctrl[PB_RST];
        end
    end

    assert_cchg_w1c_R10: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wdata[PB_CCHG] && !attach && !soft_rst) |=> !ctrl[PB_CCHG]);

    assert_rst_pulse_single_R11: assert property (@(posedge clk) disable iff (rst)
        rst_pulse |=> !rst_pulse);

    assert_detach_disables_R12: assert property (@(posedge clk) disable iff (rst)
        (detach && ctrl[PB_EN] && !wr_en && !soft_rst) |=> (!ctrl[PB_EN] && ctrl[PB_ECHG]));
endmodule

// File: rtl/usbh_regblk.sv
module usbh_regblk
    import usbh_pkg::*;
#(
    parameter int NPORTS    = 2,
    parameter int FRN_W     = 11,
    parameter int FLB_ALIGN = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [4:0]        req_addr,
    input  logic [1:0]        req_size,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    input  logic              evt_ioc,
    input  logic              evt_spd,
    input  logic              evt_err,
    input  logic              evt_resume,
    input  logic              evt_hse,
    input  logic              evt_perr,
    input  logic              evt_halt,
    input  logic [NPORTS-1:0] port_attach,
    input  logic [NPORTS-1:0] port_detach,
    input  logic [NPORTS-1:0] port_low_speed,
    output logic              irq,
    output logic              run,
    output logic              hc_reset_pulse,
    output logic              bus_reset_pulse,
    output logic [NPORTS-1:0] port_reset_pulse
);
    localparam int FLB_HI_W = 32 - FLB_ALIGN;

    acc_e              acc;
    logic              wr, rd, w_word, wr_cmd, wr_sts, wr_ien, wr_frn, wr_flb, wr_sof;
    logic              soft_rst;
    logic [NPORTS-1:0] port_wr;

    logic [15:0]         cmd_q;
    sts_t                sts_q, sts_set;
    cause_t              cause_q, cause_set;
    ien_t                ien_q;
    logic [FRN_W-1:0]    frn_q;
    logic [FLB_HI_W-1:0] flb_q;
    logic [7:0]          sof_q;
    logic [15:0]         port_ctrl [NPORTS];
    logic [31:0]         rdata_c;

    // request decode
    assign acc    = acc_e'(req_size);
    assign wr     = req_valid && req_write;
    assign rd     = req_valid && !req_write;
    assign w_word = wr && (acc == ACC_WORD) && !req_addr[0];
    assign wr_cmd = w_word && (req_addr == OFS_CMD);
    assign wr_sts = w_word && (req_addr == OFS_STS);
    assign wr_ien = w_word && (req_addr == OFS_IEN);
    assign wr_frn = w_word && (req_addr == OFS_FRN);
    assign wr_flb = wr && (acc == ACC_DWORD) && (req_addr == OFS_FLB);
    assign wr_sof = wr && (acc == ACC_BYTE) && (req_addr == OFS_SOF);
    assign soft_rst = wr_cmd && (req_wdata[1] || req_wdata[2]);

    always_comb begin
        sts_set        = '0;
        sts_set.xfer   = evt_ioc || evt_spd;
        sts_set.err    = evt_err;
        sts_set.resume = evt_resume;
        sts_set.hse    = evt_hse;
        sts_set.perr   = evt_perr;
        sts_set.halted = evt_halt;
        cause_set.done     = evt_ioc;
        cause_set.shortpkt = evt_spd;
    end

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            cmd_q   <= '0;
            sts_q   <= '0;
            cause_q <= '0;
            ien_q   <= '0;
            frn_q   <= '0;
            flb_q   <= '0;
            sof_q   <= SOF_INIT;
        end else begin
            if (wr_cmd) cmd_q <= req_wdata[15:0];
            sts_q   <= (wr_sts ? (sts_q & ~sts_t'(req_wdata[5:0])) : sts_q) | sts_set;
            cause_q <= ((wr_sts && req_wdata[0]) ? cause_t'(2'b00) : cause_q) | cause_set;
            if (wr_ien) ien_q <= ien_t'(req_wdata[3:0]);
            if (wr_frn && sts_q.halted) frn_q <= req_wdata[FRN_W-1:0];
            if (wr_flb) flb_q <= req_wdata[31:FLB_ALIGN];
            if (wr_sof) sof_q <= req_wdata[7:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hc_reset_pulse  <= 1'b0;
            bus_reset_pulse <= 1'b0;
        end else begin
            hc_reset_pulse  <= wr_cmd && req_wdata[1] && !req_wdata[2];
            bus_reset_pulse <= wr_cmd && req_wdata[2];
        end
    end

    // root-hub ports
    for (genvar gi = 0; gi < NPORTS; gi++) begin : g_port
        assign port_wr[gi] = w_word && req_addr[4] && (req_addr[3:1] == 3'(gi));
        usbh_port_csr u_port (
            .clk       (clk),
            .rst       (rst),
            .soft_rst  (soft_rst),
            .wr_en     (port_wr[gi]),
            .wdata     (req_wdata[15:0]),
            .attach    (port_attach[gi]),
            .detach    (port_detach[gi]),
            .low_speed (port_low_speed[gi]),
            .ctrl      (port_ctrl[gi]),
            .rst_pulse (port_reset_pulse[gi])
        );
    end

    usbh_irq_gen u_irq (
        .st_err    (sts_q.err),
        .st_resume (sts_q.resume),
        .st_hse    (sts_q.hse),
        .st_perr   (sts_q.perr),
        .cause     (cause_q),
        .ien       (ien_q),
        .irq       (irq)
    );

    assign run = cmd_q[0];

    // read mux
    always_comb begin
        rdata_c = 32'hFFFF_FFFF;
        unique case (acc)
            ACC_BYTE:  rdata_c = (req_addr == OFS_SOF) ? {24'd0, sof_q} : 32'h0000_00FF;
            ACC_WORD: begin
                rdata_c = 32'h0000_FFFF;
                if (req_addr[0]) begin
                    rdata_c = 32'h0000_FFFF;
                end else if (req_addr[4]) begin
                    rdata_c = {16'd0, PORT_ABSENT};
                    for (int i = 0; i < NPORTS; i++)
                        if (req_addr[3:1] == 3'(i)) rdata_c = {16'd0, port_ctrl[i]};
                end else begin
                    case (req_addr)
                        OFS_CMD: rdata_c = {16'd0, cmd_q};
                        OFS_STS: rdata_c = {26'd0, sts_q};
                        OFS_IEN: rdata_c = {28'd0, ien_q};
                        OFS_FRN: rdata_c = 32'(frn_q);
                        default: rdata_c = 32'h0000_FFFF;
                    endcase
                end
            end
            ACC_DWORD: rdata_c = (req_addr == OFS_FLB) ? {flb_q, {FLB_ALIGN{1'b0}}} : 32'hFFFF_FFFF;
            default:   rdata_c = 32'hFFFF_FFFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= rd;
            rsp_rdata <= rd ? rdata_c : '0;
        end
    end

    assert_frnum_locked_R8: assert property (@(posedge clk) disable iff (rst)
        (!sts_q.halted && !soft_rst) |=> $stable(frn_q));

    assert_softrst_defaults_R4: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (cmd_q == 16'd0 && ien_q == '0 && sof_q == SOF_INIT && !run));

    assert_cause_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_sts && req_wdata[0] && !evt_ioc && !evt_spd) |=> (cause_q == '0));

    assert_fatal_irq_R7: assert property (@(posedge clk) disable iff (rst)
        (sts_q.hse || sts_q.perr) |-> irq);

    assert_rsp_timing_R2: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(rd));
endmodule

// File: tb/usbh_regblk_tb_top.sv
`timescale 1ns/1ps
module usbh_regblk_tb_top;
    localparam int NP = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 0, req_write = 0;
    logic [4:0] req_addr = '0;
    logic [1:0] req_size = '0;
    logic [31:0] req_wdata = '0;
    logic rsp_valid;
    logic [31:0] rsp_rdata;
    logic evt_ioc = 0, evt_spd = 0, evt_err = 0, evt_resume = 0;
    logic evt_hse = 0, evt_perr = 0, evt_halt = 0;
    logic [NP-1:0] port_attach = '0, port_detach = '0, port_low_speed = '0;
    logic irq, run, hc_reset_pulse, bus_reset_pulse;
    logic [NP-1:0] port_reset_pulse;

    int n_cmp = 0;
    int n_bad = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    usbh_regblk #(.NPORTS(NP)) dut_i (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_size(req_size), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .evt_ioc(evt_ioc), .evt_spd(evt_spd), .evt_err(evt_err),
        .evt_resume(evt_resume), .evt_hse(evt_hse), .evt_perr(evt_perr),
        .evt_halt(evt_halt),
        .port_attach(port_attach), .port_detach(port_detach),
        .port_low_speed(port_low_speed),
        .irq(irq), .run(run), .hc_reset_pulse(hc_reset_pulse),
        .bus_reset_pulse(bus_reset_pulse), .port_reset_pulse(port_reset_pulse)
    );

    // monitor: pops expected read data as responses appear
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            n_cmp++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL R2: unexpected response got %h expected none", rsp_rdata);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (rsp_rdata !== e) begin
                    n_bad++;
                    $display("FAIL %s: read got %h expected %h", t, rsp_rdata, e);
                end
            end
        end
    end

    task automatic access(input bit w, input logic [4:0] a, input logic [1:0] sz,
                          input logic [31:0] d);
        req_valid = 1'b1; req_write = w; req_addr = a; req_size = sz; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic wr(input logic [4:0] a, input logic [1:0] sz, input logic [31:0] d);
        access(1'b1, a, sz, d);
    endtask

    task automatic rd(input logic [4:0] a, input logic [1:0] sz, input logic [31:0] e,
                      input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        access(1'b0, a, sz, 32'd0);
    endtask

    task automatic chk(input logic [31:0] got, input logic [31:0] e, input string t);
        n_cmp++;
        if (got !== e) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", t, got, e);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #(8 * 200000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk(irq, 0, "R1 irq");
        chk(run, 0, "R1 run");
        rd(5'h00, 2'd1, 32'h0000, "R1 cmd");
        rd(5'h02, 2'd1, 32'h0000, "R1 sts");
        rd(5'h04, 2'd1, 32'h0000, "R1 ien");
        rd(5'h06, 2'd1, 32'h0000, "R1 frn");
        rd(5'h08, 2'd2, 32'h0, "R1 flb");
        rd(5'h0C, 2'd0, 32'h40, "R1 sof");
        rd(5'h10, 2'd1, 32'h0080, "R1 port0");
        rd(5'h12, 2'd1, 32'h0080, "R1 port1");
        // R13 unmapped reads
        rd(5'h14, 2'd1, 32'hFF7F, "R13 absent port");
        rd(5'h0A, 2'd1, 32'hFFFF, "R13 word hole");
        rd(5'h0C, 2'd1, 32'hFFFF, "R13 word at byte reg");
        rd(5'h00, 2'd0, 32'hFF, "R13 byte hole");
        rd(5'h00, 2'd2, 32'hFFFF_FFFF, "R13 dword hole");
        rd(5'h08, 2'd3, 32'hFFFF_FFFF, "R2 size 3");

        // R3 command
        wr(5'h00, 2'd1, 32'h0001);
        chk(run, 1, "R3 run");
        rd(5'h00, 2'd1, 32'h0001, "R3 cmd");
        wr(5'h00, 2'd0, 32'h00FF);
        rd(5'h00, 2'd1, 32'h0001, "R13 byte write to cmd ignored");

        // R9 base and timing
        wr(5'h08, 2'd2, 32'h1234_5678);
        rd(5'h08, 2'd2, 32'h1234_5000, "R9 flb align");
        wr(5'h0C, 2'd0, 32'h2A);
        rd(5'h0C, 2'd0, 32'h2A, "R9 sof");

        // R5/R7 error and resume
        evt_err = 1; tick(); evt_err = 0;
        chk(irq, 0, "R7 err masked");
        wr(5'h04, 2'd1, 32'h1);
        chk(irq, 1, "R7 err enabled");
        evt_err = 1; wr(5'h02, 2'd1, 32'h2); evt_err = 0;
        rd(5'h02, 2'd1, 32'h02, "R5 set wins over clear");
        wr(5'h02, 2'd1, 32'h2);
        rd(5'h02, 2'd1, 32'h00, "R5 w1c");
        chk(irq, 0, "R7 err cleared");
        wr(5'h04, 2'd1, 32'h2);
        evt_resume = 1; tick(); evt_resume = 0;
        chk(irq, 1, "R7 resume");
        rd(5'h02, 2'd1, 32'h04, "R5 resume bit");
        wr(5'h02, 2'd1, 32'h4);
        chk(irq, 0, "R7 resume cleared");

        // R6 hidden cause
        wr(5'h04, 2'd1, 32'h8);
        evt_ioc = 1; tick(); evt_ioc = 0;
        rd(5'h02, 2'd1, 32'h01, "R6 ioc sets status bit0");
        chk(irq, 0, "R6 completion not seen by short enable");
        wr(5'h04, 2'd1, 32'h4);
        chk(irq, 1, "R6 completion enabled");
        evt_spd = 1; tick(); evt_spd = 0;
        wr(5'h04, 2'd1, 32'h8);
        chk(irq, 1, "R6 short packet enabled");
        wr(5'h02, 2'd1, 32'h1);
        wr(5'h04, 2'd1, 32'hC);
        chk(irq, 0, "R6 causes cleared");
        rd(5'h02, 2'd1, 32'h00, "R6 status bit0 cleared");

        // R7 unconditional sources
        wr(5'h04, 2'd1, 32'h0);
        evt_hse = 1; tick(); evt_hse = 0;
        chk(irq, 1, "R7 hse");
        wr(5'h02, 2'd1, 32'h8);
        chk(irq, 0, "R7 hse cleared");
        evt_perr = 1; tick(); evt_perr = 0;
        chk(irq, 1, "R7 perr");
        wr(5'h02, 2'd1, 32'h10);
        chk(irq, 0, "R7 perr cleared");

        // R8 frame number
        wr(5'h06, 2'd1, 32'h0123);
        rd(5'h06, 2'd1, 32'h0000, "R8 locked while running");
        evt_halt = 1; tick(); evt_halt = 0;
        rd(5'h02, 2'd1, 32'h20, "R5 halted bit");
        wr(5'h06, 2'd1, 32'hFFFF);
        rd(5'h06, 2'd1, 32'h07FF, "R8 11-bit write when halted");
        wr(5'h02, 2'd1, 32'h20);
        wr(5'h06, 2'd1, 32'h0005);
        rd(5'h06, 2'd1, 32'h07FF, "R8 locked again");

        // R12 attach/detach, R10 merge
        port_attach[0] = 1; port_low_speed[0] = 1; tick(); port_attach[0] = 0;
        rd(5'h10, 2'd1, 32'h0183, "R12 attach low speed");
        port_attach[0] = 1; port_low_speed[0] = 0; tick(); port_attach[0] = 0;
        rd(5'h10, 2'd1, 32'h0083, "R12 re-attach full speed");
        wr(5'h10, 2'd1, 32'h0004);
        rd(5'h10, 2'd1, 32'h0087, "R10 enable from data");
        wr(5'h10, 2'd1, 32'h0006);
        rd(5'h10, 2'd1, 32'h0085, "R10 connect change w1c");
        port_detach[0] = 1; tick(); port_detach[0] = 0;
        rd(5'h10, 2'd1, 32'h0089, "R12 detach enabled port");
        port_detach[0] = 1; tick(); port_detach[0] = 0;
        rd(5'h10, 2'd1, 32'h0089, "R12 detach disabled port");
        wr(5'h10, 2'd1, 32'h0008);
        rd(5'h10, 2'd1, 32'h0081, "R10 enable change w1c");

        // R11 port reset pulse
        wr(5'h12, 2'd1, 32'h0200);
        chk(32'(port_reset_pulse), 32'h2, "R11 pulse on port1");
        rd(5'h12, 2'd1, 32'h0280, "R11 reset bit stored");
        chk(32'(port_reset_pulse), 32'h0, "R11 pulse one cycle");
        wr(5'h12, 2'd1, 32'h0200);
        chk(32'(port_reset_pulse), 32'h0, "R11 no pulse when already set");
        wr(5'h12, 2'd1, 32'hF000);
        rd(5'h12, 2'd1, 32'hF080, "R10 upper bits from data");
        wr(5'h14, 2'd1, 32'hFFFF);
        rd(5'h14, 2'd1, 32'hFF7F, "R13 absent port write");
        rd(5'h10, 2'd1, 32'h0081, "R13 port0 untouched");
        rd(5'h12, 2'd1, 32'hF080, "R13 port1 untouched");

        // R4 controller reset
        evt_halt = 1; tick(); evt_halt = 0;
        wr(5'h06, 2'd1, 32'h0055);
        wr(5'h00, 2'd1, 32'h0003);
        chk(hc_reset_pulse, 1, "R4 hc pulse");
        chk(bus_reset_pulse, 0, "R4 no bus pulse");
        chk(run, 0, "R4 run cleared");
        rd(5'h00, 2'd1, 32'h0000, "R4 value not stored");
        chk(hc_reset_pulse, 0, "R4 hc pulse one cycle");
        rd(5'h0C, 2'd0, 32'h40, "R4 sof default");
        rd(5'h08, 2'd2, 32'h0, "R4 flb default");
        rd(5'h06, 2'd1, 32'h0, "R4 frn default");
        rd(5'h02, 2'd1, 32'h0, "R4 sts default");
        rd(5'h10, 2'd1, 32'h0080, "R4 port0 default");
        rd(5'h12, 2'd1, 32'h0080, "R4 port1 default");

        // R4 global reset
        wr(5'h00, 2'd1, 32'h0001);
        wr(5'h04, 2'd1, 32'h5);
        wr(5'h00, 2'd1, 32'h0006);
        chk(bus_reset_pulse, 1, "R4 bus pulse");
        chk(hc_reset_pulse, 0, "R4 global gives no hc pulse");
        rd(5'h00, 2'd1, 32'h0000, "R4 global cmd");
        chk(bus_reset_pulse, 0, "R4 bus pulse one cycle");
        rd(5'h04, 2'd1, 32'h0000, "R4 global ien");

        repeat (3) tick();
        chk(exp_q.size(), 0, "R2 all reads answered");
        summary();
        $finish;
    end
endmodule